// File: doc/BRIEF.md
# Fixed-Phase Serial Peripheral Bus Master

This block is the master side of a four-wire serial peripheral bus. It moves one byte out and one byte in at the same time. Software-facing configuration inputs set three things: the idle level of the serial clock, whether the exchange begins with the most or the least significant bit, and a divisor for the clock rate. A start strobe loads the outgoing byte. The block then lowers its single active-low select line and waits one half-period. It then produces exactly eight clock periods on a gated clock.

The clock phase is fixed. The edge that leaves the idle level (the leading edge) launches a bit onto the outgoing line. The edge that returns to the idle level (the trailing edge) samples the incoming line. As a result, the first outgoing bit appears on the very first clock edge of the frame.

After the eighth sample, the received byte is latched and a one-cycle done pulse is issued. The select line is released one half-period later. The outgoing shift register also collects the incoming bits, so the master's byte and the slave's byte trade places over the frame, as if the two registers formed one ring.

Top module: `spi_fixph_master`

## Requirements
- R1: While no frame is in progress, ss_n is 1, busy and done are 0, and sclk follows cfg_cpol with one cycle of delay.
- R2: A start pulse seen while idle sets busy and clears ss_n in the next cycle. The same edge captures tx_byte, cfg_lsb_first and cfg_div. Later changes to these inputs do not affect the running frame.
- R3: One half-period equals max(cfg_div,1)+1 clock cycles. The first sclk edge comes one half-period after ss_n falls. A frame has exactly 16 sclk edges, spaced one half-period apart, and sclk does not change between them.
- R4: Each leading edge, which takes sclk away from the captured idle level, puts the next outgoing bit on mosi. The first bit appears at the first edge.
- R5: Each trailing edge, which returns sclk to the idle level, samples miso into the shift register.
- R6: With cfg_lsb_first=1, bit 0 goes first and bit 7 last, and received bits fill bit 0 up to bit 7. With cfg_lsb_first=0, the order is reversed in both directions.
- R7: The cycle that follows the 8th trailing edge has done=1 for exactly one cycle and busy=0. In that cycle rx_byte holds the byte sampled from miso, and it keeps this value until the next done.
- R8: ss_n returns to 1 one half-period after the last sclk edge.
- R9: A start pulse during a frame, or during the half-period after the last edge, is ignored. The running frame keeps its byte and its timing, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of sclk |
| cfg_lsb_first | input | 1 | 1: least significant bit first, 0: most significant bit first |
| cfg_div | input | DIV_W | Half-period divisor; half-period = max(cfg_div,1)+1 clocks |
| tx_byte | input | DATA_W | Byte to send, captured at start |
| start | input | 1 | Single-cycle request to begin a frame |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Gated serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Frame in progress, up to the last sample |
| done | output | 1 | One-cycle pulse when rx_byte is updated |
| rx_byte | output | DATA_W | Last received byte |

## Verification
Every combination of clock polarity and bit order is crossed with divisors 0 through 3. Divisors 0 and 1 must give the same two-cycle half-period, which exposes a missing clamp. The byte pairs sent are all-zero against all-ones, single set bits at opposite ends, and alternating or irregular patterns. Sending all-zero against all-ones exposes swapped data lines. The single end bits expose a reversed bit order in either direction. A mismatched pair shows whether the received byte comes from miso or is only the recirculated transmit byte. In one frame per configuration, start is pulsed again and the transmit inputs are changed mid-frame, which separates captured configuration from live inputs.

// File: rtl/spi_fp_pkg.sv
package spi_fp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_TAIL
    } phase_e;
endpackage

// File: rtl/spi_fp_baud.sv
module spi_fp_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(1);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = (div < MIN_DIV) ? MIN_DIV : div;
        tick  = run && (cnt_q == lim);
        cnt_d = cnt_q + DIV_W'(1);
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the half-period counter never passes its clamped limit
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= lim));

    // R3: the counter restarts from zero after every tick
    a_r3_restart_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/spi_fp_shifter.sv
module spi_fp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         lead,
    input  logic         trail,
    input  logic         lsb_first,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] shift_in
);
    typedef struct packed {
        logic [W-1:0] sh;
        logic         mosi;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        shift_in = lsb_first ? {miso, s_q.sh[W-1:1]} : {s_q.sh[W-2:0], miso};
        s_d = s_q;
        if (load)       s_d.sh   = load_val;
        else if (lead)  s_d.mosi = lsb_first ? s_q.sh[0] : s_q.sh[W-1];
        else if (trail) s_d.sh   = shift_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mosi = s_q.mosi;

    // R4/R5: a single event is either a launch or a sample, never both
    a_r5_one_edge_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead && trail));

    // R4: the outgoing line moves only on a launch edge
    a_r4_mosi_on_lead_only: assert property (@(posedge clk) disable iff (!rst_n)
        !lead |=> $stable(mosi));
endmodule

// File: rtl/spi_fixph_master.sv
module spi_fixph_master
    import spi_fp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_lsb_first,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              start,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              ss_n,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EC_W  = $clog2(EDGES);
    localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(EDGES - 1);

    typedef struct packed {
        phase_e            ph;
        logic [EC_W-1:0]   ecnt;
        logic              sclk;
        logic              ss_n;
        logic              busy;
        logic              done;
        logic [DATA_W-1:0] rx;
        logic              cpol;
        logic              lsb;
        logic [DIV_W-1:0]  div;
    } ctl_t;

    ctl_t r_d, r_q;
    logic tick, lead, trail, load;
    logic [DATA_W-1:0] shift_in;

    spi_fp_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.ph != ST_IDLE),
        .div   (r_q.div),
        .tick  (tick)
    );

    spi_fp_shifter #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (tx_byte),
        .lead      (lead),
        .trail     (trail),
        .lsb_first (r_q.lsb),
        .miso      (miso),
        .mosi      (mosi),
        .shift_in  (shift_in)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        lead     = 1'b0;
        trail    = 1'b0;
        load     = 1'b0;
        unique case (r_q.ph)
            ST_IDLE: begin
                r_d.sclk = cfg_cpol;
                if (start) begin
                    r_d.ph   = ST_LEAD;
                    r_d.ss_n = 1'b0;
                    r_d.busy = 1'b1;
                    r_d.cpol = cfg_cpol;
                    r_d.lsb  = cfg_lsb_first;
                    r_d.div  = cfg_div;
                    r_d.ecnt = '0;
                    load     = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    r_d.ph   = ST_XFER;
                    r_d.sclk = ~r_q.cpol;
                    r_d.ecnt = EC_W'(1);
                    lead     = 1'b1;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    if (r_q.ecnt[0]) begin
                        trail    = 1'b1;
                        r_d.sclk = r_q.cpol;
                        if (r_q.ecnt == LAST_EDGE) begin
                            r_d.ph   = ST_TAIL;
                            r_d.done = 1'b1;
                            r_d.busy = 1'b0;
                            r_d.rx   = shift_in;
                        end else begin
                            r_d.ecnt = r_q.ecnt + EC_W'(1);
                        end
                    end else begin
                        lead     = 1'b1;
                        r_d.sclk = ~r_q.cpol;
                        r_d.ecnt = r_q.ecnt + EC_W'(1);
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    r_d.ph   = ST_IDLE;
                    r_d.ss_n = 1'b1;
                end
            end
            default: r_d.ph = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.ph   <= ST_IDLE;
            r_q.ss_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk    = r_q.sclk;
    assign ss_n    = r_q.ss_n;
    assign busy    = r_q.busy;
    assign done    = r_q.done;
    assign rx_byte = r_q.rx;

    // R1: at rest the clock line follows the polarity input
    a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == ST_IDLE && !start) |=> (sclk == $past(cfg_cpol)));

    // R2: a start taken at rest selects the slave and raises busy
    a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == ST_IDLE && start) |=> (busy && !ss_n && !done));

    // R3: the clock holds between half-period ticks
    a_r3_sclk_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph != ST_IDLE && !tick) |=> $stable(sclk));

    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done coincides with the end of busy
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8: the slave stays selected while busy
    a_r8_select_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ss_n);
endmodule

// File: tb/sim_spi_fixph_master.sv
module sim_spi_fixph_master;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int DIV_W      = 8;

    logic clk, rst_n;
    logic cfg_cpol, cfg_lsb_first, start, miso;
    logic [DIV_W-1:0] cfg_div;
    logic [W-1:0] tx_byte, rx_byte;
    logic sclk, mosi, ss_n, busy, done;

    int n_checks = 0;
    int n_fails  = 0;
    int wd       = 0;

    spi_fixph_master #(.DATA_W(W), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_lsb_first(cfg_lsb_first),
        .cfg_div(cfg_div), .tx_byte(tx_byte), .start(start), .miso(miso),
        .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .busy(busy), .done(done), .rx_byte(rx_byte)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_fails++;
            $display("FAIL watchdog R7 frame never completed actual=%0d expected<150000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input bit cp, input bit lsb, input int dv,
                             input logic [W-1:0] t, input logic [W-1:0] s, input bit inject);
        int h;
        int edges;
        logic prev;
        logic [W-1:0] got;
        h     = ((dv < 1) ? 1 : dv) + 1;
        edges = 0;
        got   = '0;
        @(negedge clk);
        cfg_cpol      = cp;
        cfg_lsb_first = lsb;
        cfg_div       = DIV_W'(dv);
        tx_byte       = t;
        start         = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && ss_n == 1'b0, "R2 busy/ss_n after start", {busy, ss_n}, 2'b10);
        chk(sclk == cp, "R1 sclk at idle level before first edge", sclk, cp);
        tx_byte       = ~t;
        cfg_lsb_first = ~lsb;
        cfg_div       = DIV_W'(dv + 3);
        prev = sclk;
        for (int cyc = 1; cyc <= 17*h + 2; cyc++) begin
            start = (inject && (cyc == 5 || cyc == 16*h + 1)) ? 1'b1 : 1'b0;
            @(negedge clk);
            if (sclk !== prev) begin
                int idx;
                int bp;
                idx = edges / 2;
                bp  = lsb ? idx : (W - 1 - idx);
                chk(cyc == h*(edges+1), "R3 edge spacing", cyc, h*(edges+1));
                if (edges % 2 == 0) begin
                    chk(sclk == ~cp, "R4 leading edge leaves idle level", sclk, ~cp);
                    got[bp] = mosi;
                    miso    = s[bp];
                end else begin
                    chk(sclk == cp, "R5 trailing edge returns to idle level", sclk, cp);
                end
                edges++;
                prev = sclk;
            end
            if (cyc == 16*h) begin
                chk(done == 1'b1, "R7 done at last sample", done, 1);
                chk(busy == 1'b0, "R7 busy falls with done", busy, 0);
                chk(rx_byte == s, "R5 R6 received byte", rx_byte, s);
            end
            if (cyc == 16*h + 1)
                chk(done == 1'b0, "R7 done one cycle wide", done, 0);
            if (cyc == 17*h - 1)
                chk(ss_n == 1'b0, "R8 ss_n held until tail ends", ss_n, 0);
            if (cyc == 17*h)
                chk(ss_n == 1'b1, "R8 ss_n released one half-period after last edge", ss_n, 1);
        end
        start = 1'b0;
        chk(edges == 16, "R3 sixteen edges per frame", edges, 16);
        chk(got == t, "R4 R6 bits seen on mosi", got, t);
        chk(rx_byte == s, "R7 rx_byte held after frame", rx_byte, s);
        if (inject)
            chk(busy == 1'b0 && ss_n == 1'b1, "R9 extra start ignored", {busy, ss_n}, 2'b01);
    endtask

    function automatic logic [W-1:0] pat(input int i, input bit which);
        case (i)
            0: pat = which ? 8'hFF : 8'h00;
            1: pat = which ? 8'h80 : 8'h01;
            2: pat = which ? 8'h3C : 8'hA5;
            3: pat = which ? 8'h00 : 8'hFF;
            default: pat = W'((i * 37 + (which ? 91 : 11)) & 8'hFF);
        endcase
    endfunction

    initial begin
        rst_n = 1'b0; cfg_cpol = 1'b0; cfg_lsb_first = 1'b0; cfg_div = '0;
        tx_byte = '0; start = 1'b0; miso = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ss_n == 1'b1, "R1 ss_n high at reset", ss_n, 1);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done low at reset", {busy, done}, 0);
        chk(sclk == 1'b0, "R1 sclk follows cpol=0", sclk, 0);
        cfg_cpol = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1, "R1 sclk follows cpol=1", sclk, 1);
        for (int cp = 0; cp < 2; cp++)
            for (int lsb = 0; lsb < 2; lsb++)
                for (int dv = 0; dv < 4; dv++)
                    for (int i = 0; i < 6; i++)
                        run_frame(cp[0], lsb[0], dv, pat(i, 0), pat(i, 1), i == 2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule